// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Generator

This block is a standard-mode two-wire serial slave (I2C, up to 100 kbit/s) that keeps a small bank of 8-bit configuration bytes for a clock generator. The clock datapath reads these bytes directly from a flat output vector. After reset each byte holds a fixed start-up value. A system clock much faster than SCL oversamples SCL and SDA. Every decision is taken on edges of the synchronised lines, so the slave has no logic clocked by SCL.

There is no register address pointer. A write transfer starts with the device address, followed by two bytes that the protocol requires but that the slave acknowledges and throws away. The data bytes after those two fill the bank from byte 0 upward until the host sends STOP. A read transfer returns a filler byte of 00h, then the bank size, then the bank from byte 0 upward, for as long as the host acknowledges.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the bank holds byte0=1Eh, byte1=FFh, byte2=FEh, byte3=00h, byte4=00h and byte5=00h. Byte k sits in bits 8k+7..8k of cfg_o. SDA is released (sda_oe_o=0).
- R2: The 7-bit device address is 69h. The address byte D2h (write) and the address byte D3h (read) are both acknowledged by pulling SDA low during the ninth clock.
- R3: An address byte with any other 7-bit address is not acknowledged. SDA stays released until the next START, and the bank does not change.
- R4: In a write, the first two bytes after the address are acknowledged and discarded. Each following byte is acknowledged and stored in order into byte 0, byte 1 and upward. Bits arrive MSB first.
- R5: STOP after any complete byte ends the write. Bytes the write did not reach keep their values.
- R6: A byte cut short by STOP or by a repeated START is never stored, not even in part.
- R7: Data bytes beyond the sixth are acknowledged and dropped. No stored byte changes because of them.
- R8: In a read, the slave sends 00h, then 06h (the bank size), then byte 0, byte 1 and upward, MSB first. Past the last byte it sends 00h. A host NACK ends the read, and SDA is released before STOP.
- R9: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. A repeated START always restarts the address phase.
- R10: The slave changes SDA only while SCL is low. It never changes SDA during an SCL high phase.
- R11: A byte appears on cfg_o only after the falling SCL edge that ends its eighth bit. It is never visible while the eighth bit is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Configuration bank, byte k in bits 8k+7..8k |

## Verification
The assertions assume that every SCL high phase and every SCL low phase lasts several system clocks longer than the synchroniser depth. They also assume that SDA moves only while SCL is low, apart from deliberate START and STOP conditions. Under those assumptions, a drive change issued right after a detected falling edge still sees SCL low. The stimulus meets these assumptions by holding each SCL phase for 20 system clocks and by moving SDA a quarter period after SCL has fallen. The reference bank is compared with cfg_o on every clock once SCL has been quiet for 8 cycles.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_WDATA,
      ST_RDATA,
      ST_RACK
   } bus_state_t;

   localparam logic [6:0] DEV_ADDR_DEFAULT = 7'h69;

endpackage

// File: rtl/cfgi2c_line_sampler.sv
module cfgi2c_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfgi2c_line_sampler: SYNC_STAGES must be at least 2");
   end

   logic [1:0] raw;
   logic [1:0] synced;
   logic [1:0] prev_q;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b11;
      else        prev_q <= synced;
   end

   assign scl_s     = synced[0];
   assign sda_s     = synced[1];
   assign scl_rise  = synced[0] & ~prev_q[0];
   assign scl_fall  = ~synced[0] & prev_q[0];
   assign start_det = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
   assign stop_det  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];

endmodule

// File: rtl/cfgi2c_bus_seq.sv
module cfgi2c_bus_seq
   import cfgi2c_pkg::*;
#(
   parameter int         NUM_BYTES = 6,
   parameter logic [6:0] DEV_ADDR  = DEV_ADDR_DEFAULT,
   localparam int        IDXW      = $clog2(NUM_BYTES + 3)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_s,
   input  logic                   sda_s,
   input  logic                   scl_rise,
   input  logic                   scl_fall,
   input  logic                   start_det,
   input  logic                   stop_det,
   input  logic [NUM_BYTES*8-1:0] cfg_i,
   output logic                   wr_en_o,
   output logic [IDXW-1:0]        wr_idx_o,
   output logic [7:0]             wr_data_o,
   output logic                   sda_oe_o
);

   localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NUM_BYTES + 2);
   localparam logic [IDXW-1:0] IDX_DATA = IDXW'(2);

   bus_state_t      state;
   logic [3:0]      bitcnt;
   logic [7:0]      shreg;
   logic            rw_q;
   logic            mack_q;
   logic            drive_q;
   logic [IDXW-1:0] idx_q;
   logic [IDXW-1:0] idx_inc;

   function automatic logic [7:0] pick(input logic [IDXW-1:0] i);
      int k;
      k = int'(i) - 2;
      if (i == '0)                       return 8'h00;
      else if (i == IDXW'(1))            return 8'(NUM_BYTES);
      else if (k >= 0 && k < NUM_BYTES)  return cfg_i[k*8 +: 8];
      else                               return 8'h00;
   endfunction

   assign idx_inc = (idx_q == IDX_LAST) ? idx_q : idx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         drive_q <= 1'b0;
         idx_q   <= '0;
      end else if (start_det) begin
         state   <= ST_ADDR;
         bitcnt  <= '0;
         drive_q <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         drive_q <= 1'b0;
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end
               if (scl_fall && bitcnt == 4'd8) begin
                  if (shreg[7:1] == DEV_ADDR) begin
                     state   <= ST_ACK;
                     drive_q <= 1'b1;
                     rw_q    <= shreg[0];
                     idx_q   <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_WDATA: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end
               if (scl_fall && bitcnt == 4'd8) begin
                  state   <= ST_ACK;
                  drive_q <= 1'b1;
                  idx_q   <= idx_inc;
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw_q) begin
                     state   <= ST_RDATA;
                     shreg   <= pick(idx_q);
                     drive_q <= ~pick(idx_q)[7];
                  end else begin
                     state   <= ST_WDATA;
                     drive_q <= 1'b0;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     state   <= ST_RACK;
                     drive_q <= 1'b0;
                     bitcnt  <= '0;
                  end else begin
                     bitcnt  <= bitcnt + 1'b1;
                     shreg   <= {shreg[6:0], 1'b0};
                     drive_q <= ~shreg[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) mack_q <= ~sda_s;
               if (scl_fall) begin
                  if (mack_q) begin
                     state   <= ST_RDATA;
                     idx_q   <= idx_inc;
                     shreg   <= pick(idx_inc);
                     drive_q <= ~pick(idx_inc)[7];
                     bitcnt  <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign wr_en_o   = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8) &&
                      !start_det && !stop_det &&
                      (idx_q >= IDX_DATA) && (idx_q < IDX_LAST);
   assign wr_idx_o  = idx_q - IDX_DATA;
   assign wr_data_o = shreg;
   assign sda_oe_o  = drive_q;

   // Drive only in the slave acknowledge slot or while sending read data (R2, R8)
   assert_drive_only_when_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drive_q |-> (state == ST_ACK || state == ST_RDATA));

   // START always reopens the address phase with SDA released (R9)
   assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && !drive_q));

   // STOP always returns to idle with SDA released (R5)
   assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !drive_q));

   // SDA pull-down starts only while SCL is low (R10)
   assert_drive_in_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_q) |-> !scl_s);

endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
   parameter int                   NUM_BYTES   = 6,
   parameter logic [NUM_BYTES*8-1:0] RESET_IMAGE = '0,
   localparam int                  IDXW        = $clog2(NUM_BYTES + 3)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDXW-1:0]        wr_idx,
   input  logic [7:0]             wr_data,
   output logic [NUM_BYTES*8-1:0] cfg_o
);

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= RESET_IMAGE[b*8 +: 8];
         else if (wr_en && wr_idx == IDXW'(b))        q <= wr_data;
      end
      assign cfg_o[b*8 +: 8] = q;
   end

   // The sequencer never targets a byte past the bank (R7)
   assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_BYTES));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
   import cfgi2c_pkg::*;
#(
   parameter int                     NUM_BYTES   = 6,
   parameter logic [6:0]             DEV_ADDR    = DEV_ADDR_DEFAULT,
   parameter int                     SYNC_STAGES = 2,
   parameter logic [NUM_BYTES*8-1:0] RESET_IMAGE = 48'h00_00_00_FE_FF_1E,
   localparam int                    IDXW        = $clog2(NUM_BYTES + 3)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe_o,
   output logic [NUM_BYTES*8-1:0] cfg_o
);

   if (NUM_BYTES < 1 || NUM_BYTES > 250) begin : g_bad_size
      $error("cfg_i2c_slave: NUM_BYTES must lie in 1..250");
   end

   logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [7:0]      wr_data;

   cfgi2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   cfgi2c_bus_seq #(.NUM_BYTES(NUM_BYTES), .DEV_ADDR(DEV_ADDR)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .cfg_i     (cfg_o),
      .wr_en_o   (wr_en),
      .wr_idx_o  (wr_idx),
      .wr_data_o (wr_data),
      .sda_oe_o  (sda_oe_o)
   );

   cfgi2c_regbank #(.NUM_BYTES(NUM_BYTES), .RESET_IMAGE(RESET_IMAGE)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .cfg_o   (cfg_o)
   );

   // The bank only moves in the cycle after a detected SCL falling edge (R11)
   assert_commit_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_fall |=> $stable(cfg_o));

endmodule

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;

   localparam int Q = 10;
   localparam int H = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic [47:0] cfg;
   logic        sda_line;

   always #5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   cfg_i2c_slave u_cfg_i2c_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe),
      .cfg_o    (cfg)
   );

   int         checks = 0;
   int         bad = 0;
   logic [7:0] mdl [6];
   int         quiet = 0;
   logic       scl_prev = 1'b1;
   logic       oe_prev = 1'b0;
   int         r10_viol = 0;
   bit         cmp_en = 1'b0;
   bit         done = 1'b0;

   // reference bank compared with the outputs on every settled clock (R4, R11)
   always begin
      @(negedge clk);
      #2;
      if (scl_m != scl_prev) quiet = 0;
      else if (quiet < 100000) quiet++;
      scl_prev = scl_m;
      if (scl_m && quiet >= 6 && sda_oe != oe_prev) r10_viol++;
      oe_prev = sda_oe;
      if (cmp_en && quiet >= 8) begin
         for (int b = 0; b < 6; b++) begin
            checks++;
            if (cfg[b*8 +: 8] !== mdl[b]) begin
               bad++;
               $display("FAIL R11 per-clock byte%0d actual=%02h expected=%02h", b, cfg[b*8 +: 8], mdl[b]);
            end
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic start_c();
      sda_m = 1'b1; wait_n(Q);
      scl_m = 1'b1; wait_n(H);
      sda_m = 1'b0; wait_n(H);
      scl_m = 1'b0; wait_n(Q);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; wait_n(Q);
      scl_m = 1'b1; wait_n(H);
      sda_m = 1'b1; wait_n(H);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wait_n(Q);
      scl_m = 1'b1; wait_n(H);
      scl_m = 1'b0; wait_n(Q);
   endtask

   task automatic byte_out(input logic [7:0] v, input int commit_idx, output logic acked);
      for (int i = 7; i >= 1; i--) bit_out(v[i]);
      sda_m = v[0]; wait_n(Q);
      scl_m = 1'b1; wait_n(H);
      scl_m = 1'b0;
      if (commit_idx >= 0 && commit_idx < 6) mdl[commit_idx] = v;
      wait_n(Q);
      sda_m = 1'b1; wait_n(Q);
      scl_m = 1'b1; wait_n(Q);
      acked = ~sda_line;
      wait_n(Q);
      scl_m = 1'b0; wait_n(Q);
   endtask

   task automatic byte_in(output logic [7:0] v, input logic mack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_n(Q);
         scl_m = 1'b1; wait_n(Q);
         v[i] = sda_line;
         wait_n(Q);
         scl_m = 1'b0; wait_n(Q);
      end
      sda_m = ~mack; wait_n(Q);
      scl_m = 1'b1; wait_n(H);
      scl_m = 1'b0; wait_n(Q);
      sda_m = 1'b1;
   endtask

   task automatic check_bank(input string tag);
      for (int b = 0; b < 6; b++) chk($sformatf("%s byte%0d", tag, b), 32'(cfg[b*8 +: 8]), 32'(mdl[b]));
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", checks, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] rv;
      logic [7:0] exp_rd [9];

      mdl[0] = 8'h1E; mdl[1] = 8'hFF; mdl[2] = 8'hFE;
      mdl[3] = 8'h00; mdl[4] = 8'h00; mdl[5] = 8'h00;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(5);
      // R1 reset image and released SDA
      check_bank("R1 reset");
      chk("R1 sda released", 32'(sda_oe), 32'd0);
      cmp_en = 1'b1;

      // R2 R4 full write: two discarded leaders then six data bytes
      start_c();
      byte_out(8'hD2, -1, a); chk("R2 write address ack", 32'(a), 32'd1);
      byte_out(8'hAA, -1, a); chk("R4 command byte ack", 32'(a), 32'd1);
      byte_out(8'h55, -1, a); chk("R4 count byte ack", 32'(a), 32'd1);
      for (int i = 0; i < 6; i++) begin
         byte_out(8'(8'h11 * (i + 1)), i, a);
         chk($sformatf("R4 data ack %0d", i), 32'(a), 32'd1);
      end
      stop_c();
      wait_n(10);
      check_bank("R4 after full write");

      // R5 short write touches byte 0 only
      start_c();
      byte_out(8'hD2, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'hA5, 0, a); chk("R5 data ack", 32'(a), 32'd1);
      stop_c();
      wait_n(10);
      check_bank("R5 after short write");

      // R7 eight data bytes, last two dropped but acknowledged
      start_c();
      byte_out(8'hD2, -1, a);
      byte_out(8'h01, -1, a);
      byte_out(8'h08, -1, a);
      for (int i = 0; i < 8; i++) begin
         byte_out(8'(8'hC0 + i), (i < 6) ? i : -1, a);
         if (i >= 6) chk($sformatf("R7 extra byte ack %0d", i), 32'(a), 32'd1);
      end
      stop_c();
      wait_n(10);
      check_bank("R7 after overflow");

      // R3 foreign address: no ack, stays released, bank untouched
      start_c();
      byte_out(8'hA4, -1, a); chk("R3 foreign address nack", 32'(a), 32'd0);
      byte_out(8'h00, -1, a); chk("R3 still released", 32'(a), 32'd0);
      byte_out(8'h3F, -1, a); chk("R3 still released 2", 32'(a), 32'd0);
      stop_c();
      wait_n(10);
      check_bank("R3 bank unchanged");

      // R6 byte cut by STOP is not stored
      start_c();
      byte_out(8'hD2, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h3C, 0, a);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
      stop_c();
      wait_n(10);
      check_bank("R6 partial byte at STOP");

      // R9 R6 repeated START mid-byte restarts address phase
      start_c();
      byte_out(8'hD2, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h00, -1, a);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      start_c();
      byte_out(8'hD2, -1, a); chk("R9 address after repeated START", 32'(a), 32'd1);
      byte_out(8'h00, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h77, 0, a);
      stop_c();
      wait_n(10);
      check_bank("R9 after repeated START");

      // R8 full read including past-end filler
      exp_rd[0] = 8'h00;
      exp_rd[1] = 8'h06;
      for (int i = 0; i < 6; i++) exp_rd[i + 2] = mdl[i];
      exp_rd[8] = 8'h00;
      start_c();
      byte_out(8'hD3, -1, a); chk("R2 read address ack", 32'(a), 32'd1);
      for (int i = 0; i < 9; i++) begin
         byte_in(rv, (i < 8));
         chk($sformatf("R8 read byte %0d", i), 32'(rv), 32'(exp_rd[i]));
      end
      chk("R8 released after NACK", 32'(sda_oe), 32'd0);
      stop_c();

      // R8 early NACK, then the bus still accepts a write
      start_c();
      byte_out(8'hD3, -1, a);
      byte_in(rv, 1'b1); chk("R8 short read dummy", 32'(rv), 32'h00);
      byte_in(rv, 1'b1); chk("R8 short read count", 32'(rv), 32'h06);
      byte_in(rv, 1'b0); chk("R8 short read byte0", 32'(rv), 32'(mdl[0]));
      chk("R8 released after early NACK", 32'(sda_oe), 32'd0);
      stop_c();
      start_c();
      byte_out(8'hD2, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h00, -1, a);
      byte_out(8'h5A, 0, a);
      byte_out(8'h01, 1, a);
      stop_c();
      wait_n(10);
      check_bank("R5 write after read");

      // R10 accumulated over the whole run
      chk("R10 SDA moves during SCL high", 32'(r10_viol), 32'd0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule